// File: doc/BRIEF.md
# Port Change-Detect Interrupt Generator

This block watches two 8-bit general-purpose I/O ports and requests an interrupt whenever a pin configured as an input no longer matches the level last captured for its port. Each port keeps its own snapshot of the synchronised pin levels. A pin that differs from its snapshot while it is an input raises that port's pending flag. The block combines both flags into one active-low, open-drain interrupt, which it drives as a pull-low enable.

A bus slave drives a one-cycle strobe for each port. The strobe marks the rising clock of the acknowledge or not-acknowledge bit of a read of that port's input register. On that strobe the port's snapshot reloads from the current synchronised pins, and the port's pending flag clears. The other port is not affected. Because the comparison is by level and not by latched edge, a pin that goes back to its captured level withdraws its own request without any read.

Top module: `gci_irq`

## Requirements
- R1: While reset is high, every snapshot follows the synchronised pins. After reset is released with the pins held steady, `port_pend_o` is 2'b00 and `irq_pull_o` is 0.
- R2: When a pin whose `dir_in_i` bit is 1 (input) rises, the owning port's `port_pend_o` bit and `irq_pull_o` go to 1 on the third rising clock edge after the change. Pin index is port*8 + bit.
- R3: A falling transition on an input pin raises the same request with the same three-edge latency as in R2.
- R4: A pin whose `dir_in_i` bit is 0 (output) never contributes: toggling it leaves `port_pend_o` and `irq_pull_o` at 0.
- R5: If an input pin returns to its captured level before any read, the request it caused drops three edges after the return.
- R6: A high `rd_ack_i[p]` at a rising edge clears `port_pend_o[p]` at that edge and reloads port p's snapshot from the synchronised pins. The levels read are then no longer a mismatch.
- R7: A read strobe for one port leaves the other port's pending bit unchanged.
- R8: Setting a pin's `dir_in_i` bit from 0 to 1 while its level differs from the port snapshot raises the port's request at the next rising edge, even though the pin did not move.
- R9: After a clearing read, every later change on an input pin of that port is detected and reported again.
- R10: `irq_pull_o` is 1 exactly when at least one bit of `port_pend_o` is 1, and it is 0 (line released) otherwise.
- R11: A pin change that reaches the compare in the same cycle as that port's read strobe is taken into the new snapshot. It raises no request, or only a short one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Raw pin levels; bit port*8+b |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_ack_i | input | 2 | Per-port read acknowledge strobe, one cycle |
| irq_pull_o | output | 1 | Pull-low enable of the open-drain interrupt line |
| port_pend_o | output | 2 | Per-port pending request |

## Verification
Single rising and falling edges show that the compare is by level in both polarities. A change followed by a return to the old level, with no read in between, shows that the block compares against a snapshot rather than latching an edge. Pending requests on both ports, followed by reads in each order, show that the ports clear independently and that a read recaptures the snapshot. Toggling a pin set as output, and then turning that same stale pin into an input, separates the masking by direction from the compare itself. A change timed to arrive with a read strobe is accepted as either outcome and then cleared.

// File: rtl/gci_pkg.sv
package gci_pkg;

    localparam int DEF_PORT_W      = 8;
    localparam int DEF_NUM_PORTS   = 2;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } pin_dir_e;

    // Per-port flag pair: registered request and its next value.
    typedef struct packed {
        logic pend;
        logic pend_nxt;
    } port_flag_t;

    // True when any input-direction pin differs from its snapshot.
    function automatic logic any_live_diff(input logic [63:0] lvl,
                                           input logic [63:0] snap,
                                           input logic [63:0] dir_in);
        return |(dir_in & (lvl ^ snap));
    endfunction

endpackage

// File: rtl/gci_sync.sv
module gci_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    // No reset: the chain keeps sampling during reset so the snapshots
    // can settle on real pin levels.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) stg_q[s] <= d_i;
            end else begin : g_next
                always_ff @(posedge clk) stg_q[s] <= stg_q[s-1];
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gci_port_cmp.sv
module gci_port_cmp
    import gci_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] dir_in_i,
    input  logic         rd_ack_i,
    output port_flag_t   flag_o
);
    logic [W-1:0] snap_q;
    logic         pend_q;
    logic         diff;
    logic         pend_nxt;

    assign diff     = any_live_diff(64'(lvl_i), 64'(snap_q), 64'(dir_in_i));
    assign pend_nxt = rd_ack_i ? 1'b0 : diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= lvl_i;
            pend_q <= 1'b0;
        end else begin
            if (rd_ack_i) snap_q <= lvl_i;
            pend_q <= pend_nxt;
        end
    end

    assign flag_o.pend     = pend_q;
    assign flag_o.pend_nxt = pend_nxt;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_ack_i |=> !pend_q);  // R6

    AST_SNAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        rd_ack_i |=> (snap_q == $past(lvl_i)));  // R6

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_ack_i && !rst) |=> $stable(snap_q));  // R5

    AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (dir_in_i == '0) |=> !pend_q);  // R4
endmodule

// File: rtl/gci_irq.sv
module gci_irq
    import gci_pkg::*;
#(
    parameter int PORT_W      = DEF_PORT_W,
    parameter int NUM_PORTS   = DEF_NUM_PORTS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
    input  logic [NUM_PORTS*PORT_W-1:0] dir_in_i,
    input  logic [NUM_PORTS-1:0]        rd_ack_i,
    output logic                        irq_pull_o,
    output logic [NUM_PORTS-1:0]        port_pend_o
);
    localparam int TOTAL_W = NUM_PORTS * PORT_W;

    logic [TOTAL_W-1:0]   lvl_s;
    port_flag_t           flag [NUM_PORTS];
    logic [NUM_PORTS-1:0] nxt_vec;
    logic                 irq_q;

    gci_sync #(.W(TOTAL_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .d_i (pin_i),
        .q_o (lvl_s)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            gci_port_cmp #(.W(PORT_W)) i_cmp (
                .clk      (clk),
                .rst      (rst),
                .lvl_i    (lvl_s[p*PORT_W +: PORT_W]),
                .dir_in_i (dir_in_i[p*PORT_W +: PORT_W]),
                .rd_ack_i (rd_ack_i[p]),
                .flag_o   (flag[p])
            );
            assign port_pend_o[p] = flag[p].pend;
            assign nxt_vec[p]     = flag[p].pend_nxt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |nxt_vec;
    end

    assign irq_pull_o = irq_q;

    AST_IRQ_FOLLOWS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_q == (|port_pend_o));  // R10
endmodule

// File: tb/test_gci_irq.sv
module test_gci_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pin = 16'hA55A;
    logic [15:0] dir = 16'hFFFF;
    logic [1:0]  rd  = 2'b00;
    logic        irq;
    logic [1:0]  pend;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [1:0] pend;
        bit         any_ok;
        string      req;
    } exp_t;
    exp_t sb[$];

    gci_irq i_gci_irq (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin),
        .dir_in_i    (dir),
        .rd_ack_i    (rd),
        .irq_pull_o  (irq),
        .port_pend_o (pend)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue an expectation lat edges from now, sorted by due.
    task automatic expect_in(input int lat, input logic [1:0] p,
                             input bit any_ok, input string req);
        exp_t e;
        int   k;
        e.due = cyc + lat; e.pend = p; e.any_ok = any_ok; e.req = req;
        k = 0;
        while (k < sb.size() && sb[k].due <= e.due) k++;
        sb.insert(k, e);
    endtask

    task automatic read_port(input int p);
        rd[p] = 1'b1;
        tick(1);
        rd = 2'b00;
    endtask

    // Monitor side: pop and compare at the due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (e.any_ok) begin
                if ((irq !== (|pend)) || $isunknown(pend)) begin
                    n_errors++;
                    $display("FAIL %s: pend=%b irq=%b, expected any pend with irq=|pend",
                             e.req, pend, irq);
                end
            end else begin
                if (e.due != cyc || pend !== e.pend) begin
                    n_errors++;
                    $display("FAIL %s: pend=%b expected %b (cycle %0d due %0d)",
                             e.req, pend, e.pend, cyc, e.due);
                end
                n_checks++;
                if (irq !== (|e.pend)) begin
                    n_errors++;
                    $display("FAIL R10 (%s): irq_pull=%b expected %b",
                             e.req, irq, |e.pend);
                end
            end
        end
    end

    initial begin
        tick(6);
        rst = 1'b0;
        expect_in(1, 2'b00, 0, "R1 after reset");
        expect_in(3, 2'b00, 0, "R1 settled");
        tick(4);

        pin[0] = 1'b1;                      // rising on port 0
        expect_in(2, 2'b00, 0, "R2 latency not yet");
        expect_in(3, 2'b01, 0, "R2 rise port0");
        tick(4);
        pin[0] = 1'b0;                      // return to captured level
        expect_in(3, 2'b00, 0, "R5 return clears");
        tick(4);

        pin[8] = 1'b0;                      // falling on port 1
        expect_in(3, 2'b10, 0, "R3 fall port1");
        tick(4);
        read_port(0);
        expect_in(0, 2'b10, 0, "R7 read port0 keeps port1");
        tick(2);
        read_port(1);
        expect_in(0, 2'b00, 0, "R6 read port1 clears");
        expect_in(3, 2'b00, 0, "R6 snapshot recaptured");
        tick(4);

        pin[8] = 1'b1;
        expect_in(3, 2'b10, 0, "R9 change after read");
        tick(4);
        read_port(1);
        expect_in(0, 2'b00, 0, "R9 cleared again");
        tick(3);

        pin[3] = ~pin[3];
        pin[12] = ~pin[12];
        expect_in(3, 2'b11, 0, "R7 both pending");
        tick(4);
        read_port(1);
        expect_in(0, 2'b01, 0, "R7 read port1 keeps port0");
        tick(2);
        read_port(0);
        expect_in(0, 2'b00, 0, "R7 read port0 clears");
        tick(3);

        dir[5] = 1'b0;                      // pin 5 becomes output
        tick(1);
        pin[5] = ~pin[5];
        expect_in(3, 2'b00, 0, "R4 output toggle ignored");
        tick(4);
        pin[5] = ~pin[5];
        expect_in(3, 2'b00, 0, "R4 output toggle back ignored");
        tick(4);
        pin[5] = ~pin[5];                   // stale vs snapshot, still output
        expect_in(3, 2'b00, 0, "R4 output stale ignored");
        tick(4);
        dir[5] = 1'b1;                      // output -> input, no edge
        expect_in(1, 2'b01, 0, "R8 dir switch raises");
        tick(3);
        read_port(0);
        expect_in(0, 2'b00, 0, "R8 cleared by read");
        tick(3);

        pin[14] = ~pin[14];                 // reaches compare with strobe
        tick(2);
        rd[1] = 1'b1;
        tick(1);
        rd = 2'b00;
        expect_in(0, 2'b00, 1, "R11 change at ack");
        expect_in(2, 2'b00, 1, "R11 after ack");
        tick(3);
        read_port(1);
        expect_in(0, 2'b00, 0, "R11 final read clears");
        tick(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule